// File: doc/BRIEF.md
# Byte-Wide SPI Master/Slave Port

This block is a serial peripheral interface endpoint that moves one byte at a time and can take either role. Software drives it through four small registers: control, status, data and clock counter. As master it produces the serial clock from the clock counter and begins shifting as soon as the data register is written. As slave it follows the select line and the serial clock that another device drives. The clock phase setting decides whether a slave transfer is bounded by the select line or by the clock edges.

Outgoing data goes straight into the shift register, because there is no transmit holding stage. Incoming data passes through a one-byte read buffer that is filled when a transfer completes. Four sticky status bits record completion, a write collision, a read overrun and a mode fault. They are cleared by reading the status register and then accessing the data register.

The slave-side inputs (serial clock, MOSI, select) pass through a synchronizer two flops deep before any edge is detected. The master samples MISO directly on its own internal edge ticks.

Top module: `spiPort`

Register map (regSel): 0 = control, 1 = status, 2 = data, 3 = clock counter. Control bits: bit0 clock phase (cpha), bit1 idle clock level (cpol), bit2 master select (1 = master), bit3 LSB-first. Status bits: bit0 transfer done, bit1 write collision, bit2 read overrun, bit3 mode fault. The select line is active low.

## Requirements
- R1: In master mode, a data register write while idle starts a transfer. The SCK period is the effective divisor D. The done bit becomes 1 exactly 8*D clock cycles after the edge that took the write, and is 0 one cycle before that.
- R2: The effective divisor is the clock counter value with bit0 cleared, and any value below 8 counts as 8. The clock counter has no effect in slave mode.
- R3: The cpha, cpol, master and LSB-first bits are captured when a transfer starts. Writing the control register during a transfer does not change the SCK level the block drives.
- R4: The first data bit appears on MOSI as soon as the write is taken. It is bit7 of the byte when control bit3 is 0 and bit0 when bit3 is 1.
- R5: SCK rests at the cpol level when idle. With cpha=0 the master samples MISO on the leading SCK edge and changes MOSI on the trailing edge. With cpha=1 it changes MOSI on the leading edge and samples MISO on the trailing edge.
- R6: In slave mode with cpha=0, a transfer starts when select goes low and completes only when select returns high. MISO presents the preloaded byte one bit per clock.
- R7: In slave mode with cpha=1, a transfer starts at the first SCK edge while selected. It completes at the eighth trailing (sampling) edge, without waiting for select to rise.
- R8: The MISO output enable is 1 only when the block is a slave and select is low.
- R9: When a transfer completes, the received byte is copied into the read buffer, and a data register read returns that buffer.
- R10: A data register write during a transfer sets status bit1 and leaves the shift register and the transfer unchanged.
- R11: If a transfer completes while the done bit is still 1, status bit2 is set and the read buffer keeps its earlier byte.
- R12: Reading the status register and then accessing the data register clears all four status bits. A data access with no status read before it clears nothing.
- R13: In master mode, select driven low sets status bit3 and aborts any transfer in progress, so the done bit is not set.
- R14: After reset, all registers read 0 and the SCK, MOSI and MISO output enables are 0 while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 2 | Register address |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (used for flag clearing) |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data, combinational on regSel |
| sckIn | input | 1 | Serial clock from a remote master |
| sckOut | output | 1 | Serial clock driven as master |
| sckOe | output | 1 | Serial clock output enable |
| mosiIn | input | 1 | Serial data received as slave |
| mosiOut | output | 1 | Serial data sent as master |
| mosiOe | output | 1 | MOSI output enable |
| misoIn | input | 1 | Serial data received as master |
| misoOut | output | 1 | Serial data sent as slave |
| misoOe | output | 1 | MISO output enable |
| sselN | input | 1 | Active-low slave select |

## Verification
The master results have fixed latencies. The first MOSI bit is due half a cycle after the edge that takes the data write, and the done bit at exactly 8*D edges after it. The bench counts those edges, samples done on the falling edge just before and just after, and then reads the byte. Slave-side effects lag the pins by the two synchronizer flops plus one edge-detect register, so the bench holds every pin level for six cycles before it samples MISO or the status. The mode-fault and clear sequences are checked only after these settle times have passed.

// File: rtl/spiPortPkg.sv
package spiPortPkg;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam logic [1:0] ADDR_DATA   = 2'd2;
  localparam logic [1:0] ADDR_CLKDIV = 2'd3;

  localparam int CTL_CPHA   = 0;
  localparam int CTL_CPOL   = 1;
  localparam int CTL_MASTER = 2;
  localparam int CTL_LSB    = 3;

  localparam int ST_DONE = 0;
  localparam int ST_WCOL = 1;
  localparam int ST_ROVR = 2;
  localparam int ST_MODF = 3;

  typedef struct packed {
    logic load;       // take wrData into the transmit shift register
    logic start;      // transfer begins: rewind bit index, clear receive shifter
    logic advance;    // present the next transmit bit
    logic sample;     // shift sampleBit into the receive shifter
    logic commit;     // copy the received byte into the read buffer
    logic lsbFirst;   // bit order in force
    logic sampleBit;  // serial input bit selected by role
  } spiStrobes_t;

endpackage

// File: rtl/spiDatapath.sv
module spiDatapath
  import spiPortPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  input  logic              doneFlag,
  output logic              txBit,
  output logic [DATA_W-1:0] rxBuf
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

  logic [DATA_W-1:0] txReg;
  logic [DATA_W-1:0] rxReg;
  logic [DATA_W-1:0] rxShift;
  logic [IDX_W-1:0]  bitIdx;

  always_comb begin
    if (strobes.lsbFirst) rxShift = {strobes.sampleBit, rxReg[DATA_W-1:1]};
    else                  rxShift = {rxReg[DATA_W-2:0], strobes.sampleBit};
  end

  assign txBit = strobes.lsbFirst ? txReg[bitIdx] : txReg[TOP_IDX - bitIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg  <= '0;
      rxReg  <= '0;
      bitIdx <= '0;
      rxBuf  <= '0;
    end else begin
      if (strobes.load) txReg <= wrData;

      if (strobes.load || strobes.start) bitIdx <= '0;
      else if (strobes.advance)          bitIdx <= bitIdx + 1'b1;

      if (strobes.start)       rxReg <= '0;
      else if (strobes.sample) rxReg <= rxShift;

      if (strobes.commit) rxBuf <= strobes.sample ? rxShift : rxReg;
    end
  end

  AST_TX_HELD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(txReg)); // R10

  AST_RXBUF_HELD_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && $past(doneFlag)) |-> $stable(rxBuf)); // R11

endmodule

// File: rtl/spiControl.sv
module spiControl
  import spiPortPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int MIN_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  input  logic              sselN,
  output spiStrobes_t       strobes,
  output logic              busy,
  output logic              doneFlag,
  output logic [3:0]        ctrlOut,
  output logic [3:0]        statusOut,
  output logic [CNT_W-1:0]  clkOut,
  output logic              sckOut,
  output logic              sckOe,
  output logic              mosiOe,
  output logic              misoOe
);

  localparam int EDGE_W = $clog2(2 * DATA_W);
  localparam int SCNT_W = $clog2(DATA_W);
  localparam logic [EDGE_W-1:0] EDGE_LAST   = EDGE_W'(2 * DATA_W - 1);
  localparam logic [SCNT_W-1:0] SAMPLE_LAST = SCNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0]  DIV_FLOOR   = CNT_W'(MIN_DIV);

  // register state
  logic [3:0]       ctrlReg;
  logic [CNT_W-1:0] clkReg;
  logic             wcolF, rovrF, modfF, armed;

  // transfer state
  logic             latCpha, latCpol, latMaster, latLsb;
  logic [CNT_W-1:0] latHalf;
  logic [CNT_W-1:0] divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [SCNT_W-1:0] sampleCnt;
  logic             sckInt;

  // input synchronizers
  logic [SYNC_STAGES-1:0] sckPipe, mosiPipe, sselPipe;
  logic sckSync, mosiSync, sselAct, sckPrev, sselActPrev;

  assign sckSync  = sckPipe[SYNC_STAGES-1];
  assign mosiSync = mosiPipe[SYNC_STAGES-1];
  assign sselAct  = ~sselPipe[SYNC_STAGES-1];

  // decoded register accesses
  logic dataWr, dataAcc, statusRd;
  assign dataWr   = wrEn && (regSel == ADDR_DATA);
  assign dataAcc  = (wrEn || rdEn) && (regSel == ADDR_DATA);
  assign statusRd = rdEn && (regSel == ADDR_STATUS);

  logic ctrlMaster, ctrlCpha, ctrlCpol, ctrlLsb;
  assign ctrlMaster = ctrlReg[CTL_MASTER];
  assign ctrlCpha   = ctrlReg[CTL_CPHA];
  assign ctrlCpol   = ctrlReg[CTL_CPOL];
  assign ctrlLsb    = ctrlReg[CTL_LSB];

  // effective divisor: even, floored at MIN_DIV
  logic [CNT_W-1:0] effDiv;
  assign effDiv = (clkReg < DIV_FLOOR) ? DIV_FLOOR : {clkReg[CNT_W-1:1], 1'b0};

  // master edge engine
  logic masterBusy, slaveBusy, mTick, mLead, mTrail, mLast;
  assign masterBusy = busy && latMaster;
  assign slaveBusy  = busy && !latMaster;
  assign mTick  = masterBusy && (divCnt == latHalf - CNT_W'(1));
  assign mLead  = mTick && !edgeCnt[0];
  assign mTrail = mTick && edgeCnt[0];
  assign mLast  = mTrail && (edgeCnt == EDGE_LAST);

  // slave edge detection
  logic cpolNow, sckEdge, sLead, sTrail, sselFall, sselRise;
  assign cpolNow  = busy ? latCpol : ctrlCpol;
  assign sckEdge  = sckSync ^ sckPrev;
  assign sLead    = sckEdge && (sckPrev == cpolNow);
  assign sTrail   = sckEdge && (sckPrev != cpolNow);
  assign sselFall = sselAct && !sselActPrev;
  assign sselRise = !sselAct && sselActPrev;

  // transfer events
  logic masterStart, slaveStart, startAny;
  logic sampleEv, advanceEv, completeEv, abortEv, wcolSet, modfSet;

  assign masterStart = dataWr && !busy && ctrlMaster && !sselAct;
  assign slaveStart  = !busy && !ctrlMaster &&
                       (ctrlCpha ? (sselAct && sckEdge) : sselFall);
  assign startAny    = masterStart || slaveStart;

  always_comb begin
    sampleEv   = 1'b0;
    advanceEv  = 1'b0;
    completeEv = 1'b0;
    abortEv    = 1'b0;
    if (masterBusy) begin
      sampleEv   = latCpha ? mTrail : mLead;
      advanceEv  = latCpha ? (mLead && (edgeCnt != '0)) : mTrail;
      abortEv    = sselAct;
      completeEv = mLast && !sselAct;
    end else if (slaveBusy) begin
      sampleEv  = latCpha ? sTrail : sLead;
      advanceEv = latCpha ? sLead : sTrail;
      if (latCpha) begin
        completeEv = sampleEv && (sampleCnt == SAMPLE_LAST) && sselAct;
        abortEv    = sselRise;
      end else begin
        completeEv = sselRise;
      end
    end
  end

  assign wcolSet = dataWr && busy;
  assign modfSet = ctrlMaster && sselAct && (!busy || latMaster);

  // strobes to the datapath
  always_comb begin
    strobes.load      = dataWr && !busy;
    strobes.start     = startAny;
    strobes.advance   = advanceEv;
    strobes.sample    = sampleEv;
    strobes.commit    = completeEv && !doneFlag;
    strobes.lsbFirst  = busy ? latLsb : ctrlLsb;
    strobes.sampleBit = latMaster ? misoIn : mosiSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe     <= '0;
      mosiPipe    <= '0;
      sselPipe    <= '1;
      sckPrev     <= 1'b0;
      sselActPrev <= 1'b0;
      ctrlReg     <= '0;
      clkReg      <= '0;
      doneFlag    <= 1'b0;
      wcolF       <= 1'b0;
      rovrF       <= 1'b0;
      modfF       <= 1'b0;
      armed       <= 1'b0;
      busy        <= 1'b0;
      latCpha     <= 1'b0;
      latCpol     <= 1'b0;
      latMaster   <= 1'b0;
      latLsb      <= 1'b0;
      latHalf     <= '0;
      divCnt      <= '0;
      edgeCnt     <= '0;
      sampleCnt   <= '0;
      sckInt      <= 1'b0;
    end else begin
      sckPipe     <= {sckPipe[SYNC_STAGES-2:0], sckIn};
      mosiPipe    <= {mosiPipe[SYNC_STAGES-2:0], mosiIn};
      sselPipe    <= {sselPipe[SYNC_STAGES-2:0], sselN};
      sckPrev     <= sckSync;
      sselActPrev <= sselAct;

      if (wrEn && (regSel == ADDR_CTRL))   ctrlReg <= wrData[3:0];
      if (wrEn && (regSel == ADDR_CLKDIV)) clkReg  <= CNT_W'(wrData);

      if (statusRd)     armed <= 1'b1;
      else if (dataAcc) armed <= 1'b0;

      // clear first, then let set events win
      if (armed && dataAcc) begin
        doneFlag <= 1'b0;
        wcolF    <= 1'b0;
        rovrF    <= 1'b0;
        modfF    <= 1'b0;
      end
      if (wcolSet) wcolF <= 1'b1;
      if (modfSet) modfF <= 1'b1;
      if (completeEv) begin
        if (doneFlag) rovrF    <= 1'b1;
        else          doneFlag <= 1'b1;
      end

      if (startAny) begin
        busy      <= 1'b1;
        latCpha   <= ctrlCpha;
        latCpol   <= ctrlCpol;
        latMaster <= ctrlMaster;
        latLsb    <= ctrlLsb;
        latHalf   <= effDiv >> 1;
        divCnt    <= '0;
        edgeCnt   <= '0;
        sampleCnt <= '0;
        sckInt    <= 1'b0;
      end else if (busy) begin
        if (completeEv || abortEv) busy <= 1'b0;
        if (latMaster) begin
          if (mTick) begin
            divCnt  <= '0;
            sckInt  <= ~sckInt;
            edgeCnt <= edgeCnt + 1'b1;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        if (sampleEv) sampleCnt <= sampleCnt + 1'b1;
      end
    end
  end

  assign ctrlOut   = ctrlReg;
  assign clkOut    = clkReg;
  assign statusOut = {modfF, rovrF, wcolF, doneFlag};

  assign sckOut = masterBusy ? (latCpol ^ sckInt) : ctrlCpol;
  assign sckOe  = ctrlMaster;
  assign mosiOe = ctrlMaster;
  assign misoOe = !ctrlMaster && !sselN;

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> !busy); // R1

  AST_SCK_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (masterBusy && !mTick && !sselAct) |=> $stable(sckOut)); // R3

  AST_MODF_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modfF) |-> !busy); // R13

endmodule

// File: rtl/spiPort.sv
module spiPort
  import spiPortPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int MIN_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              sselN
);

  spiStrobes_t       strobes;
  logic              busy;
  logic              doneFlag;
  logic              txBit;
  logic [DATA_W-1:0] rxBuf;
  logic [3:0]        ctrlOut;
  logic [3:0]        statusOut;
  logic [CNT_W-1:0]  clkOut;

  spiControl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .MIN_DIV(MIN_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) uControl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .sckIn(sckIn), .mosiIn(mosiIn), .misoIn(misoIn),
    .sselN(sselN), .strobes(strobes), .busy(busy), .doneFlag(doneFlag),
    .ctrlOut(ctrlOut), .statusOut(statusOut), .clkOut(clkOut),
    .sckOut(sckOut), .sckOe(sckOe), .mosiOe(mosiOe), .misoOe(misoOe)
  );

  spiDatapath #(.DATA_W(DATA_W)) uDatapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .busy(busy), .doneFlag(doneFlag), .txBit(txBit), .rxBuf(rxBuf)
  );

  assign mosiOut = txBit;
  assign misoOut = txBit;

  always_comb begin
    case (regSel)
      ADDR_CTRL:   rdData = DATA_W'(ctrlOut);
      ADDR_STATUS: rdData = DATA_W'(statusOut);
      ADDR_DATA:   rdData = rxBuf;
      default:     rdData = DATA_W'(clkOut);
    endcase
  end

endmodule

// File: tb/spiPort_test.sv
`timescale 1ns/1ps
module spiPort_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic sckIn = 1'b0, mosiIn = 1'b0, sselN = 1'b1;
  logic sckOut, sckOe, mosiOut, mosiOe, misoOut, misoOe;
  logic flip = 1'b0;
  logic misoIn;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign misoIn = mosiOut ^ flip;

  spiPort uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .sckIn(sckIn), .sckOut(sckOut),
    .sckOe(sckOe), .mosiIn(mosiIn), .mosiOut(mosiOut), .mosiOe(mosiOe),
    .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe), .sselN(sselN)
  );

  // {flip, ctrl[3:0] lsb/master/cpol/cpha, clock counter, tx byte}
  localparam logic [20:0] VEC [0:5] = '{
    {1'b0, 4'b0000, 8'd0,  8'hA5},
    {1'b1, 4'b0001, 8'd9,  8'h3C},
    {1'b0, 4'b0010, 8'd12, 8'h81},
    {1'b1, 4'b0011, 8'd7,  8'h5A},
    {1'b0, 4'b1000, 8'd20, 8'h01},
    {1'b1, 4'b1011, 8'd10, 8'hF0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regSel = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a);
    @(negedge clk);
    regSel = a; rdEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    regSel = a;
    #1;
    v = rdData;
  endtask

  task automatic clearFlags();
    regRead(2'd1);
    regRead(2'd2);
  endtask

  task automatic slaveRun(input logic cpha, input logic cpol, input logic lsb,
                          input logic [7:0] mo, input logic [7:0] pre);
    logic [7:0] got;
    logic [7:0] v;
    regWrite(2'd0, {lsb, 1'b0, cpol, cpha});
    regWrite(2'd2, pre);
    sckIn = cpol; sselN = 1'b1;
    waitC(6);
    chk("R8 misoOe while deselected", misoOe, 0);
    sselN = 1'b0;
    waitC(6);
    chk("R8 misoOe while selected", misoOe, 1);
    got = 8'd0;
    for (int i = 0; i < 8; i++) begin
      int bp;
      bp = lsb ? i : 7 - i;
      if (!cpha) begin
        mosiIn = mo[bp]; waitC(6);
        got[bp] = misoOut;
        sckIn = ~cpol; waitC(6);
        sckIn = cpol;  waitC(6);
      end else begin
        sckIn = ~cpol; mosiIn = mo[bp]; waitC(6);
        got[bp] = misoOut;
        sckIn = cpol; waitC(6);
      end
    end
    if (cpha) begin
      peek(2'd1, v);
      chk("R7 done at eighth sampling edge", v[0], 1);
      sselN = 1'b1; waitC(6);
      chk("R7 slave MISO byte", got, pre);
    end else begin
      peek(2'd1, v);
      chk("R6 done waits for deselect", v[0], 0);
      sselN = 1'b1; waitC(6);
      peek(2'd1, v);
      chk("R6 done after deselect", v[0], 1);
      chk("R6 slave MISO byte", got, pre);
    end
    peek(2'd2, v);
    chk("R9 slave receive buffer", v, mo);
    chk("R8 misoOe released", misoOe, 0);
    clearFlags();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    waitC(3);
    rstN = 1'b1;
    waitC(2);

    // R14 reset state
    peek(2'd0, v); chk("R14 ctrl reset", v, 8'h00);
    peek(2'd1, v); chk("R14 status reset", v, 8'h00);
    peek(2'd2, v); chk("R14 data reset", v, 8'h00);
    peek(2'd3, v); chk("R14 clock counter reset", v, 8'h00);
    chk("R14 output enables reset", {sckOe, mosiOe, misoOe}, 3'b000);

    // master vectors over cpha/cpol/bit order/divisor
    for (int i = 0; i < 6; i++) begin
      logic [20:0] vec;
      logic [3:0] ctl;
      logic [7:0] cnt, tx, expRx;
      int d;
      vec = VEC[i];
      ctl = vec[19:16]; cnt = vec[15:8]; tx = vec[7:0];
      d = (cnt < 8) ? 8 : int'({cnt[7:1], 1'b0});
      expRx = vec[20] ? ~tx : tx;
      flip = vec[20];
      regWrite(2'd3, cnt);
      regWrite(2'd0, ctl | 4'b0100);
      clearFlags();
      chk("R5 SCK idle at cpol", sckOut, ctl[1]);
      regWrite(2'd2, tx);
      chk("R4 first MOSI bit", mosiOut, ctl[3] ? tx[0] : tx[7]);
      repeat (8 * d - 1) @(posedge clk);
      @(negedge clk);
      peek(2'd1, v);
      chk("R1 R2 done not yet", v[0], 0);
      @(posedge clk);
      @(negedge clk);
      peek(2'd1, v);
      chk("R1 R2 done at 8*D", v[0], 1);
      peek(2'd2, v);
      chk("R5 R9 received byte", v, expRx);
    end
    flip = 1'b0;

    // R3 control change mid-transfer
    regWrite(2'd3, 8'd8);
    regWrite(2'd0, 4'b0100);
    clearFlags();
    regWrite(2'd2, 8'h6E);
    regWrite(2'd0, 4'b0110);
    chk("R3 SCK keeps latched cpol", sckOut, 0);
    waitC(70);
    peek(2'd2, v);
    chk("R3 transfer unaffected", v, 8'h6E);
    regWrite(2'd0, 4'b0100);
    clearFlags();

    // R10 write collision
    regWrite(2'd2, 8'h96);
    waitC(10);
    regWrite(2'd2, 8'h00);
    waitC(60);
    peek(2'd1, v);
    chk("R10 collision flagged", v, 8'h03);
    peek(2'd2, v);
    chk("R10 shift register kept", v, 8'h96);

    // R11 overrun
    regWrite(2'd2, 8'h11);
    waitC(70);
    peek(2'd1, v);
    chk("R11 overrun flagged", v, 8'h07);
    peek(2'd2, v);
    chk("R11 buffer keeps first byte", v, 8'h96);

    // R12 clearing
    regRead(2'd2);
    peek(2'd1, v);
    chk("R12 data access alone keeps flags", v, 8'h07);
    clearFlags();
    peek(2'd1, v);
    chk("R12 flags cleared", v, 8'h00);

    // R13 mode fault
    regWrite(2'd2, 8'hC3);
    waitC(10);
    sselN = 1'b0;
    waitC(5);
    sselN = 1'b1;
    waitC(70);
    peek(2'd1, v);
    chk("R13 fault set and no done", v, 8'h08);
    regWrite(2'd2, 8'h24);
    peek(2'd1, v);
    chk("R13 no collision after abort", v[1], 0);
    waitC(70);
    peek(2'd1, v);
    chk("R13 new transfer completes", v, 8'h09);
    peek(2'd2, v);
    chk("R13 new byte", v, 8'h24);
    clearFlags();

    // slave mode, clock counter set to a value that would matter as master (R2)
    regWrite(2'd3, 8'd3);
    slaveRun(1'b0, 1'b0, 1'b0, 8'hC6, 8'h3B);
    slaveRun(1'b1, 1'b1, 1'b1, 8'h5D, 8'hE2);
    slaveRun(1'b1, 1'b0, 1'b0, 8'h99, 8'h47);
    slaveRun(1'b0, 1'b1, 1'b1, 8'h0F, 8'hA0);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule